// File: doc/BRIEF.md
# Command-Driven Status and Error Flag Bank

This block holds the state word of a serial controller: a run/configure enable bit, a master-select bit and six sticky error flags. Software never writes the readable status word. Instead it issues a separate 16-bit command word, and each command bit either raises or lowers exactly one flag. A bit written as 1 acts, and a bit written as 0 leaves its flag alone. A cleared enable bit means configuration mode. A set enable bit means operational mode.

Error detectors elsewhere in the controller send one-cycle pulses on `hw_err`. Each pulse raises its flag only when the matching enable line from the control register is on. The mode-error pulse has no enable line. The bank drives the readable status word, which also carries a live busy bit, and one error interrupt that is the OR of the six error flags. If a hardware pulse arrives in the same cycle as a software clear of the same flag, the pulse wins, so no error is lost.

Top module: `ctl_status_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag resets to 0 whatever the command inputs are, and `err_irq` is 0.
- R2: A command write (`cmd_wr`=1) with a set bit at 1 sets its flag. The set bits are: enable 1, master select 3, receive underflow 5, mode error 7, transmit overflow 12, receive overflow 13, abort 14, transmit underflow 15.
- R3: A command write with a clear bit at 1 clears its flag. The clear bits are: enable 0, master select 2, receive underflow 4, mode error 6, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11.
- R4: Command bits written as 0 leave their flags unchanged, and no command bit has any effect while `cmd_wr` is 0.
- R5: When a single write has both the set bit and the clear bit of a flag at 1, that flag keeps its value.
- R6: `hw_err` bits 1..5 (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) set their flags when `err_enable` bits 0..4 are on, respectively.
- R7: An `hw_err` pulse on bits 1..5 has no effect while its `err_enable` bit is 0. `hw_err` bit 0 (mode error) has no enable line and always sets its flag.
- R8: An enabled hardware pulse sets its flag even when the same cycle's command clears it.
- R9: `err_irq` is 1 exactly when at least one of the six error flags is set. The enable and master-select bits never raise it.
- R10: The status word places enable at bit 0, master select at 1, mode error at 7, transmit overflow at 8, receive overflow at 9, abort at 10, transmit underflow at 11 and receive underflow at 12. Bit 13 follows `busy_in` in the same cycle, and all other bits read 0.
- R11: A flag change caused by a command or a pulse becomes visible on `status` right after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word; each 1 bit sets or clears one flag |
| err_enable | input | 5 | Enable lines for the five gated hardware error sources |
| hw_err | input | 6 | Hardware error pulses: mode, tx overflow, rx overflow, abort, tx underflow, rx underflow |
| busy_in | input | 1 | Live busy indication from the shift engine |
| status | output | 16 | Readable status word |
| err_irq | output | 1 | Combined error interrupt |

## Verification
Each flag is one register stage, so a command or pulse applied in one cycle shows on `status` and `err_irq` just after the next rising edge. The busy bit and the interrupt's dependence on the flags involve no register and no delay. The bench drives inputs on the falling edge and probes once a little after driving, where the old flags must still be showing. It probes again on the following falling edge, where the new flags must be present. Expected words come from an arithmetic model of the command and pulse rules, applied over directed corner cases and several thousand pseudo-random vectors.

// File: rtl/ctl_status_pkg.sv
// Package: shared constants and bit-map functions for the status flag bank.
// Flag index order used internally:
//   0 enable, 1 master select, 2 mode error, 3 tx overflow,
//   4 rx overflow, 5 abort, 6 tx underflow, 7 rx underflow.
package ctl_status_pkg;

    localparam int NUM_FLAGS   = 8;
    localparam int CMD_WIDTH   = 16;
    localparam int STAT_WIDTH  = 16;
    localparam int NUM_HW_SRC  = 6;
    localparam int NUM_GATES   = 5;
    localparam int BUSY_POS    = 13;
    localparam int NO_SOURCE   = -1;

    // Flags that feed the error interrupt (the six error flags).
    localparam logic [NUM_FLAGS-1:0] ERR_FLAG_MASK = 8'b1111_1100;

    // Position of each flag in the readable status word.
    function automatic int flag_stat_pos(input int idx);
        case (idx)
            0: return 0;
            1: return 1;
            2: return 7;
            3: return 8;
            4: return 9;
            5: return 10;
            6: return 11;
            default: return 12;
        endcase
    endfunction

    // Command bit that sets each flag.
    function automatic int flag_set_bit(input int idx);
        case (idx)
            0: return 1;
            1: return 3;
            2: return 7;
            3: return 12;
            4: return 13;
            5: return 14;
            6: return 15;
            default: return 5;
        endcase
    endfunction

    // Command bit that clears each flag.
    function automatic int flag_clr_bit(input int idx);
        case (idx)
            0: return 0;
            1: return 2;
            2: return 6;
            3: return 8;
            4: return 9;
            5: return 10;
            6: return 11;
            default: return 4;
        endcase
    endfunction

    // Hardware pulse index feeding each flag, or NO_SOURCE.
    function automatic int flag_hw_src(input int idx);
        return (idx < 2) ? NO_SOURCE : idx - 2;
    endfunction

    // Enable line gating each flag's hardware source, or NO_SOURCE (ungated).
    function automatic int flag_gate(input int idx);
        return (idx < 3) ? NO_SOURCE : idx - 3;
    endfunction

endpackage

// File: rtl/ctl_status_cmd_decode.sv
// Module: ctl_status_cmd_decode
// Turns a command word write into per-flag set and clear requests.
// Assumes: cmd_wr qualifies cmd_data for one cycle; bit map from the package.
module ctl_status_cmd_decode
    import ctl_status_pkg::*;
#(
    parameter int N_FLAGS = NUM_FLAGS,
    parameter int CMD_W   = CMD_WIDTH
) (
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_data,
    output logic [N_FLAGS-1:0] set_req,
    output logic [N_FLAGS-1:0] clr_req
);

    // One set and one clear request per flag, each taken from its own command bit.
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_req
        localparam int SB = flag_set_bit(i);
        localparam int CB = flag_clr_bit(i);
        assign set_req[i] = cmd_wr & cmd_data[SB];
        assign clr_req[i] = cmd_wr & cmd_data[CB];
    end

endmodule

// File: rtl/ctl_status_flag.sv
// Module: ctl_status_flag
// One sticky flag. A hardware set has top priority. A software set or clear
// acts only when it is alone; set and clear together hold the value.
// Assumes: synchronous active-low reset; hw_set already gated by its enable.
module ctl_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    output logic flag_q
);

    // Flag register update: reset, then hardware set, then lone software set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hw_set)
            flag_q <= 1'b1;
        else if (sw_set && !sw_clr)
            flag_q <= 1'b1;
        else if (sw_clr && !sw_set)
            flag_q <= 1'b0;
    end

    // R2: a lone software set takes effect after the edge.
    p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_set && !sw_clr) |-> flag_q);

    // R3: a lone software clear with no hardware event empties the flag.
    p_sw_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_clr && !sw_set && !hw_set) |-> !flag_q);

    // R4: with no request of any kind the flag holds.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !sw_set && !sw_clr && !hw_set) |-> $stable(flag_q));

    // R5: set and clear together, without hardware, hold the flag.
    p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_set && sw_clr && !hw_set) |-> $stable(flag_q));

    // R8: a hardware set is never lost to a simultaneous clear.
    p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hw_set) |-> flag_q);

endmodule

// File: rtl/ctl_status_irq.sv
// Module: ctl_status_irq
// Combines the selected flags into one level interrupt.
// Assumes: MASK marks the flags that count as errors.
module ctl_status_irq #(
    parameter int                 N_FLAGS = 8,
    parameter logic [N_FLAGS-1:0] MASK    = '1
) (
    input  logic [N_FLAGS-1:0] flags,
    output logic               irq
);

    // Interrupt is the OR of all masked flags.
    always_comb begin
        irq = |(flags & MASK);
    end

endmodule

// File: rtl/ctl_status_bank.sv
// Module: ctl_status_bank (top)
// Status word of a serial controller: enable, master select and six sticky
// error flags, driven by a write-one command word and gated hardware pulses.
// Assumes: hw_err bits are single-cycle pulses; err_enable is static per cycle.
module ctl_status_bank
    import ctl_status_pkg::*;
#(
    parameter int CMD_W  = CMD_WIDTH,
    parameter int STAT_W = STAT_WIDTH,
    parameter int HW_W   = NUM_HW_SRC,
    parameter int GATE_W = NUM_GATES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic [GATE_W-1:0] err_enable,
    input  logic [HW_W-1:0]   hw_err,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status,
    output logic              err_irq
);

    localparam int NF = NUM_FLAGS;

    logic [NF-1:0] set_req;
    logic [NF-1:0] clr_req;
    logic [NF-1:0] hw_set;
    logic [NF-1:0] flag_q;

    ctl_status_cmd_decode #(
        .N_FLAGS (NF),
        .CMD_W   (CMD_W)
    ) u_decode (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    for (genvar i = 0; i < NF; i++) begin : g_flag
        localparam int HWI = flag_hw_src(i);
        localparam int GI  = flag_gate(i);

        // Hardware set path: none, ungated, or gated by its enable line.
        if (HWI == NO_SOURCE) begin : g_nohw
            assign hw_set[i] = 1'b0;
        end else if (GI == NO_SOURCE) begin : g_ungated
            assign hw_set[i] = hw_err[HWI];
        end else begin : g_gated
            assign hw_set[i] = hw_err[HWI] & err_enable[GI];

            // R7: with its enable off and no software set, a clear flag stays clear.
            p_gate_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(flag_q[i]) && !$past(err_enable[GI])
                 && !$past(set_req[i])) |-> !flag_q[i]);
        end

        ctl_status_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_set (set_req[i]),
            .sw_clr (clr_req[i]),
            .hw_set (hw_set[i]),
            .flag_q (flag_q[i])
        );
    end

    // Status word assembly: flags at their positions, live busy, zeros elsewhere.
    always_comb begin
        status = '0;
        for (int i = 0; i < NF; i++) begin
            status[flag_stat_pos(i)] = flag_q[i];
        end
        status[BUSY_POS] = busy_in;
    end

    ctl_status_irq #(
        .N_FLAGS (NF),
        .MASK    (ERR_FLAG_MASK)
    ) u_irq (
        .flags (flag_q),
        .irq   (err_irq)
    );

    // R9: interrupt agrees with the error field of the status word.
    p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (status[12:7] != 6'd0));

endmodule

// File: tb/ctl_status_bank_bench.sv
// Bench for ctl_status_bank: directed corner cases plus a pseudo-random sweep,
// checked against an arithmetic model of the command and pulse rules.
module ctl_status_bank_bench;

    localparam int WATCHDOG_CYCLES = 150000;
    localparam int SWEEP_CYCLES    = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [4:0]  err_enable = '0;
    logic [5:0]  hw_err = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status;
    logic        err_irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_flags = '0;   // flag bits only, status layout
    logic [31:0] rng = 32'h1234_5679;

    // Encodings from the requirements, flag order:
    // enable, msel, mode, tx ovf, rx ovf, abort, tx unf, rx unf
    int POS [8] = '{0, 1, 7, 8, 9, 10, 11, 12};
    int SETB[8] = '{1, 3, 7, 12, 13, 14, 15, 5};
    int CLRB[8] = '{0, 2, 6, 8, 9, 10, 11, 4};
    int HWB [8] = '{-1, -1, 0, 1, 2, 3, 4, 5};
    int GATE[8] = '{-1, -1, -1, 0, 1, 2, 3, 4};

    always #2.5 clk = ~clk;

    ctl_status_bank u_ctl_status_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .err_enable (err_enable),
        .hw_err     (hw_err),
        .busy_in    (busy_in),
        .status     (status),
        .err_irq    (err_irq)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [15:0] model_next(input logic [15:0] cur, input logic r,
            input logic w, input logic [15:0] c, input logic [4:0] en, input logic [5:0] hw);
        logic [15:0] nx = cur;
        if (!r) return 16'h0000;
        for (int i = 0; i < 8; i++) begin
            logic s  = w & c[SETB[i]];
            logic cl = w & c[CLRB[i]];
            logic h  = 1'b0;
            if (HWB[i] >= 0) h = hw[HWB[i]] & ((GATE[i] < 0) ? 1'b1 : en[GATE[i]]);
            if (h)            nx[POS[i]] = 1'b1;
            else if (s && !cl) nx[POS[i]] = 1'b1;
            else if (cl && !s) nx[POS[i]] = 1'b0;
        end
        return nx;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: status/irq actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [16:0] expect_word(input logic [15:0] f, input logic b);
        logic [15:0] s = f;
        s[13] = b;
        return {s, (s[12:7] != 6'd0)};
    endfunction

    // One cycle: drive at the falling edge, probe before the edge (old flags),
    // then probe at the next falling edge (new flags).
    task automatic step(input logic r, input logic w, input logic [15:0] c,
                        input logic [4:0] en, input logic [5:0] hw, input logic b,
                        input string req);
        rst_n = r; cmd_wr = w; cmd_data = c; err_enable = en; hw_err = hw; busy_in = b;
        #1;
        check("R11", {status, err_irq}, expect_word(exp_flags, b));
        exp_flags = model_next(exp_flags, r, w, c, en, hw);
        @(negedge clk);
        check(req, {status, err_irq}, expect_word(exp_flags, b));
    endtask

    initial begin
        @(negedge clk);
        // R1: reset dominates a full command and pulses.
        step(1'b0, 1'b1, 16'hFFFF, 5'h1F, 6'h3F, 1'b0, "R1");
        step(1'b0, 1'b1, 16'hF0AA, 5'h1F, 6'h3F, 1'b0, "R1");
        step(1'b1, 1'b0, 16'h0000, 5'h00, 6'h00, 1'b0, "R1");

        // R2: set each flag alone.
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b1, 16'h1 << SETB[i], 5'h0, 6'h0, 1'b0, "R2");

        // R4: strobe low ignores a full word; zero word with strobe does nothing.
        step(1'b1, 1'b0, 16'hFFFF, 5'h0, 6'h0, 1'b0, "R4");
        step(1'b1, 1'b0, 16'h0F55, 5'h0, 6'h0, 1'b0, "R4");
        step(1'b1, 1'b1, 16'h0000, 5'h0, 6'h0, 1'b0, "R4");

        // R5: set and clear together hold every flag (all set).
        step(1'b1, 1'b1, 16'hFFFF, 5'h0, 6'h0, 1'b0, "R5");

        // R3: clear each flag alone.
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b1, 16'h1 << CLRB[i], 5'h0, 6'h0, 1'b0, "R3");

        // R5: both halves on an empty bank keep it empty.
        step(1'b1, 1'b1, 16'hFFFF, 5'h0, 6'h0, 1'b0, "R5");

        // R7: disabled sources ignored, mode error ungated.
        step(1'b1, 1'b0, 16'h0000, 5'h00, 6'h3E, 1'b0, "R7");
        step(1'b1, 1'b0, 16'h0000, 5'h00, 6'h01, 1'b0, "R7");
        step(1'b1, 1'b1, 16'h0040, 5'h00, 6'h00, 1'b0, "R3");

        // R6: each gated source with only its own enable on.
        for (int g = 0; g < 5; g++) begin
            step(1'b1, 1'b0, 16'h0000, 5'h1 << g, 6'h2 << g, 1'b0, "R6");
            step(1'b1, 1'b0, 16'h0000, ~(5'h1 << g), 6'h2 << g, 1'b0, "R7");
        end

        // R8: pulses beat a simultaneous clear of all error flags.
        step(1'b1, 1'b1, 16'h0F50, 5'h1F, 6'h3F, 1'b0, "R8");
        step(1'b1, 1'b1, 16'h0F50, 5'h1F, 6'h00, 1'b0, "R3");

        // R9: enable and master select alone keep the interrupt low.
        step(1'b1, 1'b1, 16'h000A, 5'h00, 6'h00, 1'b0, "R9");
        step(1'b1, 1'b1, 16'h1000, 5'h00, 6'h00, 1'b0, "R9");
        step(1'b1, 1'b1, 16'h0100, 5'h00, 6'h00, 1'b0, "R9");

        // R10: busy bit follows the input, other positions stay zero.
        step(1'b1, 1'b0, 16'h0000, 5'h00, 6'h00, 1'b1, "R10");
        step(1'b1, 1'b1, 16'hFFFF, 5'h00, 6'h00, 1'b1, "R10");
        step(1'b1, 1'b0, 16'h0000, 5'h00, 6'h00, 1'b0, "R10");

        // Pseudo-random sweep with sparse command and pulse bits.
        for (int n = 0; n < SWEEP_CYCLES; n++) begin
            logic [31:0] a, b2;
            rng = next_rng(rng); a  = rng;
            rng = next_rng(rng); b2 = rng;
            step((a[31:28] != 4'h0), a[27], a[15:0] & b2[15:0], b2[20:16],
                 a[21:16] & b2[26:21], b2[31], "R11");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule